// File: doc/BRIEF.md
# Two-Digit Quotient Estimator (128-bit by 64-bit)

This unit produces a fast 64-bit estimate of the quotient of a 128-bit dividend, presented as a high and a low 64-bit half, by a 64-bit divisor. The divisor must be normalised, meaning its top bit is set. The estimate is built as two 32-bit digits. For each digit, the unit divides by the divisor's upper 32 bits and uses a restoring 64/32 divider for that step. After the upper digit, the unit forms a 128-bit partial remainder. If the remainder is negative, it is repaired by adding the divisor back.

The unit is used as a helper inside a floating-point divide datapath. The caller raises `start_i` for one cycle with the operands, then waits for a one-cycle `done_o` pulse. The estimate then stays on `quot_o` until the next result is delivered. Dividends whose high half is not below the divisor take a short path that returns all ones.

Top module: `qest_div128`

## Requirements
- R1: When the dividend high half is greater than or equal to the divisor, the estimate is all ones (0xFFFFFFFFFFFFFFFF). `done_o` for it is seen after the second rising edge that follows the accepting edge.
- R2: The upper digit (estimate bits 63:32) starts as follows. It is 0xFFFFFFFF when the divisor's upper 32 bits, placed at bits 63:32 of a 64-bit word, are not above the dividend high half. Otherwise it is the floor of the dividend high half divided by the divisor's upper 32 bits.
- R3: The partial remainder is the 128-bit dividend minus the 128-bit product of the divisor and the trial estimate (upper digit at bits 63:32, zeros below), in modulo-2^128 arithmetic.
- R4: While bit 127 of the partial remainder is set, the estimate is reduced by 2^32 and the divisor shifted left by 32 is added to the 128-bit remainder. With a normalised divisor this happens at most twice.
- R5: After the repair, the remainder is below the divisor shifted left by 32. Its realigned 64-bit form is remainder bits 95:32.
- R6: The lower digit (estimate bits 31:0) is 0xFFFFFFFF when the divisor's upper 32 bits placed at bits 63:32 are not above the realigned remainder. Otherwise it is the floor of the realigned remainder divided by the divisor's upper 32 bits.
- R7: A `start_i` pulse while `busy_o` is high is ignored. It neither changes the result in flight nor produces an extra `done_o`.
- R8: `done_o` is a single-cycle pulse, one per accepted start. `quot_o` changes only in the cycle `done_o` is high and holds its value otherwise.
- R9: After reset `busy_o` and `done_o` are low and `quot_o` is zero.
- R10: `busy_o` is high from the edge that accepts a start up to the edge that raises `done_o`. It is low in the cycle `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; operands are taken when idle |
| num_hi_i | input | 64 | Dividend bits 127:64 |
| num_lo_i | input | 64 | Dividend bits 63:0 |
| den_i | input | 64 | Divisor, bit 63 expected set |
| busy_o | output | 1 | Estimation in progress |
| done_o | output | 1 | One-cycle result strobe |
| quot_o | output | 64 | Quotient estimate, held until the next result |

## Verification
The internal invariants assume a normalised divisor. The two-correction bound, the repaired remainder staying below the shifted divisor, and the digit divider's running remainder staying below its divisor all rely on the top divisor bit being set. The bench therefore forces bit 63 of every divisor it drives, whether random or hand-picked. It keeps the dividend high half below the divisor on the long path by folding larger random values down by one divisor. Saturation cases are then added explicitly at and above the divisor, and where only the upper-digit saturation test trips.

// File: rtl/qest_pkg.sv
// Shared types for the quotient estimator.
// Assumes nothing beyond a 3-bit state encoding.
package qest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DIG1 = 3'd1,
        ST_MUL  = 3'd2,
        ST_FIX  = 3'd3,
        ST_DIG2 = 3'd4,
        ST_FIN  = 3'd5
    } qest_state_e;

endpackage

// File: rtl/qest_wide_mul.sv
// Combinational 2H x 2H -> 4H multiplier built from four H x H partial
// products. The carry out of the middle-term sum lands at bit 3H.
// Assumes unsigned operands.
module qest_wide_mul #(
    parameter int H = 32
) (
    input  logic [2*H-1:0] a_i,
    input  logic [2*H-1:0] b_i,
    output logic [4*H-1:0] p_o
);
    localparam int W  = 2 * H;
    localparam int PW = 4 * H;

    logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
    logic [W:0]   mid_sum;

    // Form the four partial products and sum the cross terms.
    always_comb begin
        pp_ll   = W'(a_i[H-1:0]) * W'(b_i[H-1:0]);
        pp_lh   = W'(a_i[W-1:H]) * W'(b_i[H-1:0]);
        pp_hl   = W'(a_i[H-1:0]) * W'(b_i[W-1:H]);
        pp_hh   = W'(a_i[W-1:H]) * W'(b_i[W-1:H]);
        mid_sum = {1'b0, pp_lh} + {1'b0, pp_hl};
        p_o     = {pp_hh, pp_ll} + (PW'(mid_sum) << H);
    end

endmodule

// File: rtl/qest_digit_div.sv
// Restoring divider producing one DIG_W-bit quotient digit from a
// 2*DIG_W-bit dividend and a DIG_W-bit divisor in DIG_W cycles.
// Assumes the dividend's upper half is below the divisor, so the
// quotient fits in DIG_W bits.
module qest_digit_div #(
    parameter int DIG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [2*DIG_W-1:0] num_i,
    input  logic [DIG_W-1:0]   den_i,
    output logic               done_o,
    output logic [DIG_W-1:0]   quo_o
);
    localparam int NW    = 2 * DIG_W;
    localparam int CNT_W = $clog2(DIG_W + 1);

    logic [DIG_W-1:0] rem_q, qsh_q, den_q;
    logic [NW-1:0]    num_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DIG_W:0]   trial, diff;
    logic             fits;

    // Shift in the next dividend bit and compare with the divisor.
    always_comb begin
        trial = {rem_q, qsh_q[DIG_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = trial >= {1'b0, den_q};
    end

    // Load on go, then run one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            qsh_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                rem_q <= num_i[NW-1:DIG_W];
                qsh_q <= num_i[DIG_W-1:0];
                den_q <= den_i;
                num_q <= num_i;
                cnt_q <= CNT_W'(DIG_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? diff[DIG_W-1:0] : trial[DIG_W-1:0];
                qsh_q <= {qsh_q[DIG_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = qsh_q;

    AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < den_q)); // R6
    AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (NW'(qsh_q) * NW'(den_q) + NW'(rem_q) == num_q)); // R2

endmodule

// File: rtl/qest_div128.sv
// Two-digit quotient estimator: 128-bit dividend over a 64-bit divisor.
// Upper digit by digit division, remainder repair by add-back, lower
// digit from the realigned remainder. Assumes divisor bit 63 is set.
module qest_div128
    import qest_pkg::*;
#(
    parameter int DIG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2*DIG_W-1:0]   num_hi_i,
    input  logic [2*DIG_W-1:0]   num_lo_i,
    input  logic [2*DIG_W-1:0]   den_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [2*DIG_W-1:0]   quot_o
);
    localparam int W  = 2 * DIG_W;
    localparam int NW = 4 * DIG_W;
    localparam logic [W-1:0] STEP = W'(1) << DIG_W;

    qest_state_e      state_q;
    logic [NW-1:0]    num_q, rem_q;
    logic [W-1:0]     den_q, z_q;
    logic [1:0]       fix_cnt_q;
    logic             hist_ok_q;

    logic [NW-1:0]    prod;
    logic [W-1:0]     realign, dhi_in_sh, dhi_q_sh;
    logic             sat_in, top_sat_in, low_sat;
    logic             div_go, div_done;
    logic [W-1:0]     div_num;
    logic [DIG_W-1:0] div_den, div_quo;

    // Saturation tests and remainder realignment.
    always_comb begin
        dhi_in_sh  = {den_i[W-1:DIG_W], {DIG_W{1'b0}}};
        dhi_q_sh   = {den_q[W-1:DIG_W], {DIG_W{1'b0}}};
        sat_in     = num_hi_i >= den_i;
        top_sat_in = dhi_in_sh <= num_hi_i;
        realign    = rem_q[3*DIG_W-1:DIG_W];
        low_sat    = dhi_q_sh <= realign;
    end

    // Select operands and launch the shared digit divider.
    always_comb begin
        div_go  = 1'b0;
        div_num = realign;
        div_den = den_q[W-1:DIG_W];
        if (state_q == ST_IDLE) begin
            div_num = num_hi_i;
            div_den = den_i[W-1:DIG_W];
            div_go  = start_i && !sat_in && !top_sat_in;
        end else if (state_q == ST_FIX) begin
            div_go  = !rem_q[NW-1] && !low_sat;
        end
    end

    qest_digit_div #(.DIG_W(DIG_W)) u_digit (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .num_i  (div_num),
        .den_i  (div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    qest_wide_mul #(.H(DIG_W)) u_mul (
        .a_i (den_q),
        .b_i (z_q),
        .p_o (prod)
    );

    // Sequencer: saturation, digits, remainder repair and result delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            num_q     <= '0;
            rem_q     <= '0;
            den_q     <= '0;
            z_q       <= '0;
            fix_cnt_q <= '0;
            quot_o    <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    num_q     <= {num_hi_i, num_lo_i};
                    den_q     <= den_i;
                    fix_cnt_q <= '0;
                    if (sat_in) begin
                        z_q     <= '1;
                        state_q <= ST_FIN;
                    end else if (top_sat_in) begin
                        z_q     <= {{DIG_W{1'b1}}, {DIG_W{1'b0}}};
                        state_q <= ST_MUL;
                    end else begin
                        state_q <= ST_DIG1;
                    end
                end
                ST_DIG1: if (div_done) begin
                    z_q     <= {div_quo, {DIG_W{1'b0}}};
                    state_q <= ST_MUL;
                end
                ST_MUL: begin
                    rem_q   <= num_q - prod;
                    state_q <= ST_FIX;
                end
                ST_FIX: begin
                    if (rem_q[NW-1]) begin
                        z_q       <= z_q - STEP;
                        rem_q     <= rem_q + (NW'(den_q) << DIG_W);
                        fix_cnt_q <= fix_cnt_q + 2'd1;
                    end else if (low_sat) begin
                        z_q[DIG_W-1:0] <= '1;
                        state_q        <= ST_FIN;
                    end else begin
                        state_q <= ST_DIG2;
                    end
                end
                ST_DIG2: if (div_done) begin
                    z_q[DIG_W-1:0] <= div_quo;
                    state_q        <= ST_FIN;
                end
                ST_FIN: begin
                    quot_o  <= z_q;
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Marks that one post-reset edge has passed, so history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok_q <= 1'b0;
        else        hist_ok_q <= 1'b1;
    end

    assign busy_o = (state_q != ST_IDLE);

    AST_SAT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (num_hi_i >= den_i)) |=> ##1 (done_o && (quot_o == '1))); // R1
    AST_FIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX) |-> (fix_cnt_q <= 2'd2)); // R4
    AST_REM_REPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX && !rem_q[NW-1]) |-> (rem_q < (NW'(den_q) << DIG_W))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok_q)
        !done_o |-> $stable(quot_o)); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(den_q)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10

endmodule

// File: tb/qest_div128_tb_top.sv
`timescale 1ns/1ps
// Bench for the quotient estimator: a behavioural 128-bit model,
// directed saturation cases, random normalised divisors and a
// per-clock monitor of the strobe and the held result.
module qest_div128_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [63:0]  num_hi_i = '0, num_lo_i = '0, den_i = '0;
    logic         busy_o, done_o;
    logic [63:0]  quot_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit pending  = 1'b0;
    bit finished = 1'b0;
    logic [63:0] prev_quot = '0;

    always #4 clk = ~clk;

    qest_div128 dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .num_hi_i(num_hi_i), .num_lo_i(num_lo_i), .den_i(den_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural model of the estimate in 128-bit arithmetic.
    function automatic logic [63:0] model(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m);
        logic [127:0] r;
        logic [63:0]  z, mh, rr;
        if (nh >= m) return '1;
        mh = m >> 32;
        if ((mh << 32) <= nh) z = 64'hFFFF_FFFF_0000_0000;
        else                  z = (nh / mh) << 32;
        r = {nh, nl} - 128'(m) * 128'(z);
        for (int k = 0; k < 8 && r[127]; k++) begin
            z = z - 64'h1_0000_0000;
            r = r + (128'(m) << 32);
        end
        rr = r[95:32];
        if ((mh << 32) <= rr) z = z | 64'hFFFF_FFFF;
        else                  z = z | (rr / mh);
        return z;
    endfunction

    // Per-clock monitor of the strobe and the held result (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                check(pending, "R8 unexpected done", 64'(done_o), 64'(pending));
                pending = 1'b0;
            end else begin
                check(quot_o == prev_quot, "R8 hold", quot_o, prev_quot);
            end
            prev_quot = quot_o;
        end
    end

    // Run one estimate; returns result and latency in cycles.
    task automatic run_op(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m,
                          input bit poke_busy, output logic [63:0] res, output int lat);
        @(negedge clk);
        pending  = 1'b1;
        num_hi_i = nh; num_lo_i = nl; den_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        if (!done_o) check(busy_o == 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
        if (poke_busy && busy_o) begin
            num_hi_i = '1; den_i = 64'h8000_0000_0000_0000; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check(done_o == 1'b1, "R10 done seen", 64'(done_o), 64'd1);
        check(busy_o == 1'b0, "R10 idle with done", 64'(busy_o), 64'd0);
        res = quot_o;
    endtask

    task automatic do_case(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m, input string req);
        logic [63:0] r, e;
        int lat;
        e = model(nh, nl, m);
        run_op(nh, nl, m, 1'b0, r, lat);
        check(r == e, req, r, e);
    endtask

    initial begin
        logic [63:0] r, e, m, nh, nl;
        int lat;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(busy_o == 1'b0, "R9 busy", 64'(busy_o), 64'd0);
        check(done_o == 1'b0, "R9 done", 64'(done_o), 64'd0);
        check(quot_o == '0, "R9 quot", quot_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 saturation: equal and above, short latency
        m = 64'h9234_5678_9ABC_DEF0;
        run_op(m, 64'h1, m, 1'b0, r, lat);
        check(r == '1, "R1 equal", r, '1);
        check(lat == 2, "R1 latency", 64'(lat), 64'd2);
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h8000_0000_0000_0001, 1'b0, r, lat);
        check(r == '1, "R1 above", r, '1);

        // R2 upper-digit saturation while high half is still below divisor
        do_case(64'h8000_0000_0000_0001, 64'h1234_5678_9ABC_DEF0, 64'h8000_0000_FFFF_FFFF, "R2 top digit sat");
        do_case(64'hC000_0000_7000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hC000_0000_8000_0000, "R2 R4 sat with repair");
        // R6 lower-digit boundary: dividend just below divisor
        do_case(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R6 low digit near sat");
        do_case(64'h0, 64'h0, 64'h8000_0000_0000_0000, "R3 zero dividend");
        do_case(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R5 small dividend");

        // R7 start pulse while busy is ignored
        m = 64'hA5A5_0000_1234_5678;
        e = model(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, m);
        run_op(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, m, 1'b1, r, lat);
        check(r == e, "R7 ignored start", r, e);

        // R8 result holds during idle cycles
        repeat (6) @(negedge clk);
        check(quot_o == e, "R8 held after idle", quot_o, e);

        // R3 R4 R5 R6 random normalised divisors
        for (int i = 0; i < 400; i++) begin
            m  = {1'b1, $urandom(), $urandom()} ;
            m[63] = 1'b1;
            nh = {$urandom(), $urandom()};
            if (nh >= m) nh = nh - m;
            if (i % 5 == 0) nh = m - 64'(1 + $urandom_range(0, 3));
            nl = {$urandom(), $urandom()};
            if (i % 7 == 0) nl = '1;
            do_case(nh, nl, m, "R3 R4 R5 R6 random");
        end

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule